// File: doc/BRIEF.md
# JTAG Flash Page Buffer Loader

This block sits behind a JTAG TAP controller. It fills a flash page buffer one byte at a time while the page-load instruction (code 0x6) is held in the instruction register. An 8-bit byte register shifts serially on the test clock. It forms the low eight bits of the wider programming command register, which lies outside this block. Each Update-DR pulse copies the shifted byte into a holding register and starts a short, fixed-length write sequence toward the page buffer.

The sequencer works out where each byte goes. Bytes fill the 16-bit words of the page low half first, then high half. The word address moves forward just before every low byte except the first one after the instruction is entered. Because of this, the first byte lands on the address that was set up beforehand, and writing the final word of a page leaves the counter inside that page. An Update-DR that arrives while a write is still running is reported and dropped.

Top module: `jtag_page_loader`

## Requirements
- R1: While the instruction equals 0x6 and `shift_dr` is high, each clock edge shifts `tdi` into bit 7 of the byte register and moves the other bits one place toward bit 0. `tdo` always shows bit 0, so a new byte shifted in pushes the previous byte out, least significant bit first.
- R2: When the instruction is anything other than 0x6, `shift_dr` and `update_dr` have no effect. The byte register is unchanged, no write starts and `upd_err` stays low.
- R3: An accepted Update-DR (sampled at edge T) raises `pb_we` for exactly one cycle: the cycle that follows edge T+WR_LAT-1. The default WR_LAT is 4, and WR_LAT may not exceed 11.
- R4: Throughout a write, `pb_data` holds the byte that was in the byte register at the accepting edge.
- R5: `pb_hi` gives the byte lane of each write, where 0 means the low byte and 1 means the high byte. Lanes alternate on every accepted update, and the first update after the instruction is entered uses the low lane.
- R6: The word address steps up by one at the acceptance of every low-lane byte except the first after instruction entry. A high-lane byte reuses the address of the low byte before it, so loading the last word of a page does not advance into the next page.
- R7: A one-cycle `addr_load` pulse sets the word address to `addr_in`. The first byte after instruction entry is written at exactly that address.
- R8: An `ir_update` pulse while `instr` equals 0x6 resets the lane to low and re-arms the suppression of the first increment.
- R9: An Update-DR that arrives while a write is in progress raises `upd_err` for one cycle after that edge. The dropped update starts no write and changes neither lane nor address.
- R10: After reset, `pb_we`, `upd_err`, `tdo` and `pb_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | INSTR_W | Current JTAG instruction |
| ir_update | input | 1 | Pulse: instruction register updated |
| tdi | input | 1 | Serial test data in |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | Pulse: TAP is in Update-DR |
| addr_load | input | 1 | Pulse: load word address from `addr_in` |
| addr_in | input | ADDR_W | Word address from the command path |
| tdo | output | 1 | Serial data out (bit 0 of byte register) |
| pb_we | output | 1 | Page-buffer write strobe |
| pb_hi | output | 1 | Byte lane of the write (1 = high) |
| pb_data | output | 8 | Byte to write |
| pb_addr | output | ADDR_W | Word address of the write |
| upd_err | output | 1 | Pulse: update dropped because a write was busy |

## Verification
A wrong internal state in this block shows up at the page-buffer port. A lane toggle that is out of step puts `pb_hi` in the wrong lane on the very next strobe. A first-byte flag that is set wrongly shifts `pb_addr` by one word, starting with the first write after instruction entry. A write timer that is stuck busy produces a false `upd_err` one cycle after the next update, or produces a missing strobe within WR_LAT cycles. A byte register that was corrupted during an ignored shift only becomes visible on `tdo` while the next byte is being shifted in. For that reason the checks compare the bytes that come out on `tdo` against the byte loaded before.

// File: rtl/jpl_pkg.sv
package jpl_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEF_PAGELOAD = 4'h6;
    localparam int MAX_WR_LAT = 11;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        lane_e             lane;
    } wr_beat_t;

    function automatic lane_e flip_lane(input lane_e l);
        return (l == LANE_LO) ? LANE_HI : LANE_LO;
    endfunction

    function automatic logic needs_step(input lane_e l, input logic first);
        return (l == LANE_LO) && !first;
    endfunction

endpackage

// File: rtl/jpl_byte_sr.sv
module jpl_byte_sr
    import jpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sin,
    output logic [BYTE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {sin, q[BYTE_W-1:1]};
        end
    end

endmodule

// File: rtl/jpl_wr_timer.sv
module jpl_wr_timer #(
    parameter int WR_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic fire
);

    localparam int CNT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_LAT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end
        end else if (cnt_q == LAST) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire = busy && (cnt_q == LAST);

endmodule

// File: rtl/jpl_sequencer.sv
module jpl_sequencer
    import jpl_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic              accept,
    input  logic              reject,
    input  logic [BYTE_W-1:0] sr_byte,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    output wr_beat_t          beat_q,
    output lane_e             lane_q,
    output logic              first_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q  <= LANE_LO;
            first_q <= 1'b1;
        end else if (enter) begin
            lane_q  <= LANE_LO;
            first_q <= 1'b1;
        end else if (accept) begin
            lane_q  <= flip_lane(lane_q);
            first_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (addr_load) begin
            addr_q <= addr_in;
        end else if (accept && needs_step(lane_q, first_q)) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '{data: '0, lane: LANE_LO};
        end else if (accept) begin
            beat_q <= '{data: sr_byte, lane: lane_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= reject;
        end
    end

endmodule

// File: rtl/jtag_page_loader.sv
module jtag_page_loader
    import jpl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int INSTR_W = 4,
    parameter int WR_LAT = 4,
    parameter logic [INSTR_W-1:0] PAGELOAD_CODE = INSTR_W'(DEF_PAGELOAD)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               ir_update,
    input  logic               tdi,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               addr_load,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic               tdo,
    output logic               pb_we,
    output logic               pb_hi,
    output logic [7:0]         pb_data,
    output logic [ADDR_W-1:0]  pb_addr,
    output logic               upd_err
);

    if (WR_LAT < 1 || WR_LAT > MAX_WR_LAT) begin : g_bad_lat
        $error("WR_LAT must be in 1..11");
    end

    logic              active;
    logic              enter;
    logic              accept;
    logic              reject;
    logic              wr_busy;
    logic              wr_fire;
    logic [BYTE_W-1:0] sr_q;
    wr_beat_t          beat;
    lane_e             lane_now;
    logic              first_now;

    assign active = (instr == PAGELOAD_CODE);
    assign enter  = ir_update && active;
    assign accept = update_dr && active && !wr_busy;
    assign reject = update_dr && active && wr_busy;

    jpl_byte_sr u_sr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_dr && active),
        .sin      (tdi),
        .q        (sr_q)
    );

    jpl_wr_timer #(.WR_LAT(WR_LAT)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (wr_busy),
        .fire  (wr_fire)
    );

    jpl_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enter     (enter),
        .accept    (accept),
        .reject    (reject),
        .sr_byte   (sr_q),
        .addr_load (addr_load),
        .addr_in   (addr_in),
        .beat_q    (beat),
        .lane_q    (lane_now),
        .first_q   (first_now),
        .addr_q    (pb_addr),
        .err_q     (upd_err)
    );

    assign tdo     = sr_q[0];
    assign pb_we   = wr_fire;
    assign pb_hi   = beat.lane;
    assign pb_data = beat.data;

endmodule

// File: rtl/jpl_checker.sv
module jpl_checker #(
    parameter int ADDR_W = 15,
    parameter int WR_LAT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              update_dr,
    input logic              active,
    input logic              enter,
    input logic              accept,
    input logic              wr_busy,
    input logic              lane_now,
    input logic              first_now,
    input logic              addr_load,
    input logic              pb_we,
    input logic              pb_hi,
    input logic [7:0]        pb_data,
    input logic [ADDR_W-1:0] pb_addr,
    input logic              upd_err
);

    localparam int CW = $clog2(WR_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(WR_LAT - 1);

    logic [CW-1:0] since;
    logic          tracking;
    logic          have_last;
    logic          last_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            since    <= '0;
            tracking <= 1'b0;
        end else if (accept) begin
            since    <= '0;
            tracking <= 1'b1;
        end else if (tracking) begin
            if (since == LAST) tracking <= 1'b0;
            else since <= since + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_last <= 1'b0;
            last_hi   <= 1'b0;
        end else if (accept && first_now) begin
            have_last <= 1'b0;
        end else if (pb_we) begin
            have_last <= 1'b1;
            last_hi   <= pb_hi;
        end
    end

    AST_ERR_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        update_dr && active && wr_busy |=> upd_err); // R9
    AST_WE_TIMING: assert property (@(posedge clk) disable iff (rst)
        pb_we |-> tracking && since == LAST); // R3
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        wr_busy && !accept |=> $stable(pb_data)); // R4
    AST_LANE_ALT: assert property (@(posedge clk) disable iff (rst)
        pb_we && have_last |-> pb_hi != last_hi); // R5
    AST_HI_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        accept && lane_now && !addr_load |=> $stable(pb_addr)); // R6
    AST_LO_STEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        accept && !lane_now && !first_now && !addr_load |=> pb_addr == $past(pb_addr) + 1'b1); // R6
    AST_FIRST_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        accept && first_now && !addr_load |=> $stable(pb_addr)); // R7
    AST_ENTER_RESETS: assert property (@(posedge clk) disable iff (rst)
        enter |=> !lane_now && first_now); // R8
    AST_NO_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(update_dr && active) |=> !upd_err); // R2

endmodule

bind jtag_page_loader jpl_checker #(.ADDR_W(ADDR_W), .WR_LAT(WR_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .update_dr (update_dr),
    .active    (active),
    .enter     (enter),
    .accept    (accept),
    .wr_busy   (wr_busy),
    .lane_now  (lane_now),
    .first_now (first_now),
    .addr_load (addr_load),
    .pb_we     (pb_we),
    .pb_hi     (pb_hi),
    .pb_data   (pb_data),
    .pb_addr   (pb_addr),
    .upd_err   (upd_err)
);

// File: tb/tb_jtag_page_loader.sv
module tb_jtag_page_loader;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 15;
    localparam int WR_LAT = 4;
    localparam int NVEC = 6;

    // {data, expected lane, expected word address}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 15'h003E},
        {8'h3C, 1'b1, 15'h003E},
        {8'hF0, 1'b0, 15'h003F},
        {8'h0F, 1'b1, 15'h003F},
        {8'h81, 1'b0, 15'h0040},
        {8'h7E, 1'b1, 15'h0040}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        instr = 4'h0;
    logic              ir_update = 1'b0;
    logic              tdi = 1'b0;
    logic              shift_dr = 1'b0;
    logic              update_dr = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              tdo;
    logic              pb_we;
    logic              pb_hi;
    logic [7:0]        pb_data;
    logic [ADDR_W-1:0] pb_addr;
    logic              upd_err;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_page_loader #(.ADDR_W(ADDR_W), .WR_LAT(WR_LAT)) dut (
        .clk(clk), .rst(rst), .instr(instr), .ir_update(ir_update),
        .tdi(tdi), .shift_dr(shift_dr), .update_dr(update_dr),
        .addr_load(addr_load), .addr_in(addr_in), .tdo(tdo),
        .pb_we(pb_we), .pb_hi(pb_hi), .pb_data(pb_data),
        .pb_addr(pb_addr), .upd_err(upd_err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_instr(input logic [3:0] code);
        instr = code;
        ir_update = 1'b1;
        @(negedge clk);
        ir_update = 1'b0;
    endtask

    task automatic set_addr(input logic [ADDR_W-1:0] a);
        addr_in = a;
        addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic shift_in(input logic [7:0] b, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            got[i] = tdo;
            tdi = b[i];
            shift_dr = 1'b1;
            @(negedge clk);
        end
        shift_dr = 1'b0;
    endtask

    // Pulse Update-DR and watch the write window.
    task automatic do_write(input logic exp_we, input logic [7:0] d,
                            input logic h, input logic [ADDR_W-1:0] a);
        int hits = 0;
        int hit_n = 0;
        logic got_h = 1'b0;
        logic [ADDR_W-1:0] got_a = '0;
        logic [7:0] got_d = '0;
        logic err_seen = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
        for (int n = 1; n <= WR_LAT + 1; n++) begin
            if (pb_we) begin
                hits++;
                hit_n = n;
                got_h = pb_hi;
                got_a = pb_addr;
                got_d = pb_data;
            end
            if (upd_err) err_seen = 1'b1;
            @(negedge clk);
        end
        if (exp_we) begin
            chk(hits == 1, "R3", hits, 1);
            chk(hit_n == WR_LAT, "R3", hit_n, WR_LAT);
            chk(got_d == d, "R4", got_d, d);
            chk(got_h == h, "R5", got_h, h);
            chk(got_a == a, "R6", got_a, a);
        end else begin
            chk(hits == 0, "R2", hits, 0);
        end
        chk(!err_seen, "R9", err_seen, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        logic [7:0] prev;
        logic err_seen;
        int hits;
        logic got_h;
        logic [ADDR_W-1:0] got_a;
        prev = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(pb_we == 1'b0, "R10", pb_we, 0);
        chk(upd_err == 1'b0, "R10", upd_err, 0);
        chk(tdo == 1'b0, "R10", tdo, 0);
        chk(pb_addr == '0, "R10", pb_addr, 0);

        // R7/R8: enter instruction, set base address
        load_instr(4'h6);
        set_addr(15'h003E);

        for (int i = 0; i < NVEC; i++) begin
            shift_in(VEC[i][23:16], got);
            chk(got == prev, "R1", got, prev);
            do_write(1'b1, VEC[i][23:16], VEC[i][15], VEC[i][14:0]);
            prev = VEC[i][23:16];
            if (i == 3) chk(pb_addr == 15'h003F, "R6", pb_addr, 15'h003F);
        end

        // R9: collision while busy
        shift_in(8'h55, got);
        chk(got == 8'h7E, "R1", got, 8'h7E);
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
        @(negedge clk);
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
        err_seen = upd_err;
        chk(err_seen, "R9", err_seen, 1);
        hits = 0;
        got_h = 1'b0;
        got_a = '0;
        for (int n = 0; n < WR_LAT + 2; n++) begin
            if (pb_we) begin
                hits++;
                got_h = pb_hi;
                got_a = pb_addr;
            end
            @(negedge clk);
        end
        chk(hits == 1, "R9", hits, 1);
        chk(got_h == 1'b0 && got_a == 15'h0041, "R6", got_a, 15'h0041);
        shift_in(8'h66, got);
        do_write(1'b1, 8'h66, 1'b1, 15'h0041);

        // R2: another instruction ignores shift and update
        load_instr(4'h5);
        shift_in(8'h99, got);
        do_write(1'b0, 8'h00, 1'b0, '0);
        chk(pb_addr == 15'h0041, "R2", pb_addr, 15'h0041);

        // R8: re-entry resets lane and suppresses increment
        load_instr(4'h6);
        shift_in(8'h77, got);
        chk(got == 8'h66, "R2", got, 8'h66);
        do_write(1'b1, 8'h77, 1'b0, 15'h0041);

        // R7: address load mid-page
        set_addr(15'h1234);
        shift_in(8'h12, got);
        do_write(1'b1, 8'h12, 1'b1, 15'h1234);
        shift_in(8'h34, got);
        do_write(1'b1, 8'h34, 1'b0, 15'h1235);

        finish_run();
    end

endmodule